// File: doc/BRIEF.md
# Stage-2 Address Translation Cache with Machine Tags

This block caches the results of the second address-translation stage, the step that turns a guest's intermediate physical address into a real physical address. It holds a small, fully associative set of 4 KB page mappings. Each entry is tagged with the identifier of the virtual machine that owned it when it was filled. The identifier is taken from a field of the 64-bit translation base register. Because every lookup compares that tag, several virtual machines can share the cache: a switch between them needs no flush, and an entry can never match for every machine.

A lookup presents an address and an access type (read or write). One cycle later the block returns a hit with the physical address, a permission fault, or a miss. A miss raises a one-cycle walk request that carries the address and the machine identifier. An external walker answers with a fill, which the cache writes into an empty slot, into the slot that already holds the same page, or into a round-robin victim. Maintenance inputs clear the whole cache or only the entries of one machine.

Top module: `vmid_s2_tlb`

## Requirements
- R1: A lookup presented on `lu_valid` gets its response one cycle later, with `rsp_valid` high for exactly that cycle. `rsp_valid` is low in every other cycle.
- R2: A hit requires a valid entry whose page number (address bits 39:12) and machine tag both equal the lookup's. The returned `rsp_pa` is the entry's frame number above the unmodified address bits 11:0.
- R3: The current machine identifier is bits 55:48 of `vttb_base`. All other bits of that register have no effect on lookups.
- R4: Changing the current identifier removes no entry. Entries of other identifiers simply miss, and no entry matches an identifier other than its own.
- R5: A missing lookup raises `walk_req` in the response cycle, with `walk_ipa` equal to the looked-up address and `walk_vmid` equal to the current identifier. `walk_req` is never high together with `rsp_hit`.
- R6: Each entry carries a read-allowed bit and a write-allowed bit. A hit whose access (`lu_write`=1 means write, 0 means read) is not allowed gives `rsp_hit`=1, `rsp_fault`=1, `rsp_pa`=0 and no walk request.
- R7: A fill whose page and identifier match a valid entry overwrites that entry, so no two entries ever match the same lookup.
- R8: Any other fill takes the lowest-numbered invalid entry. When all entries are valid, it replaces the entry named by a round-robin pointer. The pointer starts at entry 0 and advances by one, wrapping, after each such replacement.
- R9: `inv_vmid_valid` clears exactly the entries whose tag equals `inv_vmid`, taking effect for lookups from the next cycle on.
- R10: `inv_all` clears every entry, taking effect from the next cycle on.
- R11: A fill that arrives in the same cycle as either invalidate is dropped. A lookup in the same cycle as a fill or an invalidate sees the contents from before that cycle.
- R12: After reset every entry is invalid, the round-robin pointer is 0, and `rsp_valid` and `walk_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vttb_base | input | 64 | Translation base register; identifier in bits 55:48 |
| lu_valid | input | 1 | Lookup request |
| lu_ipa | input | 40 | Intermediate physical address to translate |
| lu_write | input | 1 | Access type: 1 write, 0 read |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Matching entry found |
| rsp_fault | output | 1 | Hit with a disallowed access |
| rsp_pa | output | 40 | Translated physical address, zero unless a clean hit |
| walk_req | output | 1 | Miss strobe to the walker |
| walk_ipa | output | 40 | Address to walk |
| walk_vmid | output | 8 | Identifier to walk under |
| fill_valid | input | 1 | Walker result strobe |
| fill_ipa | input | 40 | Address that was walked (bits 39:12 used) |
| fill_vmid | input | 8 | Identifier of the walked mapping |
| fill_pa | input | 40 | Physical address of the page (bits 39:12 used) |
| fill_rd | input | 1 | Read allowed |
| fill_wr | input | 1 | Write allowed |
| inv_all | input | 1 | Clear all entries |
| inv_vmid_valid | input | 1 | Clear the entries of one identifier |
| inv_vmid | input | 8 | Identifier to clear |

## Verification
Round-robin replacement and duplicate suppression are the hardest behaviours to reach from the ports. The pointer only moves once all sixteen entries are valid. A duplicate shows up only as an extra eviction long after the fill that created it. The stimulus overwrites an existing page and then fills exactly enough distinct pages to reach sixteen entries, so a duplicating design would evict a live entry. It then opens two holes by clearing one identifier, refills them, and adds further fills. Which entries survive shows invalid-first selection, the pointer's start at entry 0, and its advance by one.

// File: rtl/s2tlb_pkg.sv
package s2tlb_pkg;
  parameter int IPA_W    = 40;
  parameter int PA_W     = 40;
  parameter int PAGE_W   = 12;
  parameter int VMID_W   = 8;
  parameter int BASE_W   = 64;
  parameter int VMID_LSB = 48;
  localparam int TAG_W = IPA_W - PAGE_W;
  localparam int PPN_W = PA_W - PAGE_W;
endpackage

// File: rtl/s2tlb_cam.sv
module s2tlb_cam #(
  parameter int N      = 16,
  parameter int TAG_W  = 28,
  parameter int VMID_W = 8
) (
  input  logic [N-1:0]             vld,
  input  logic [N-1:0][TAG_W-1:0]  tags,
  input  logic [N-1:0][VMID_W-1:0] vmids,
  input  logic [TAG_W-1:0]         key_tag,
  input  logic [VMID_W-1:0]        key_vmid,
  output logic [N-1:0]             hit
);
  // One comparator per entry; the identifier is always part of the key.
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = vld[g] && (tags[g] == key_tag) && (vmids[g] == key_vmid);
  end
endmodule

// File: rtl/s2tlb_victim.sv
module s2tlb_victim #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  ent_vld,
  input  logic [N-1:0]  dup_hit,
  input  logic          alloc,
  output logic [IW-1:0] sel_idx
);
  logic [IW-1:0] rr_q, rr_d;
  logic          use_rr;

  always_comb begin
    sel_idx = rr_q;
    for (int i = N - 1; i >= 0; i--) begin
      if (!ent_vld[i]) sel_idx = IW'(i);
    end
    for (int i = 0; i < N; i++) begin
      if (dup_hit[i]) sel_idx = IW'(i);
    end
    use_rr = !(|dup_hit) && (&ent_vld);
  end

  always_comb begin
    rr_d = rr_q;
    if (alloc && use_rr) begin
      rr_d = (rr_q == IW'(N - 1)) ? '0 : rr_q + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end
endmodule

// File: rtl/vmid_s2_tlb.sv
module vmid_s2_tlb
  import s2tlb_pkg::*;
#(
  parameter int NUM_ENT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BASE_W-1:0] vttb_base,
  input  logic              lu_valid,
  input  logic [IPA_W-1:0]  lu_ipa,
  input  logic              lu_write,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              walk_req,
  output logic [IPA_W-1:0]  walk_ipa,
  output logic [VMID_W-1:0] walk_vmid,
  input  logic              fill_valid,
  input  logic [IPA_W-1:0]  fill_ipa,
  input  logic [VMID_W-1:0] fill_vmid,
  input  logic [PA_W-1:0]   fill_pa,
  input  logic              fill_rd,
  input  logic              fill_wr,
  input  logic              inv_all,
  input  logic              inv_vmid_valid,
  input  logic [VMID_W-1:0] inv_vmid
);
  localparam int IW = $clog2(NUM_ENT);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // Entry storage
  logic [NUM_ENT-1:0]             vld_q, vld_d, we;
  logic [NUM_ENT-1:0][TAG_W-1:0]  tag_q;
  logic [NUM_ENT-1:0][VMID_W-1:0] vmid_q;
  logic [NUM_ENT-1:0][PPN_W-1:0]  ppn_q;
  logic [NUM_ENT-1:0]             rd_q, wr_q;

  logic [VMID_W-1:0] cur_vmid;
  assign cur_vmid = vttb_base[VMID_LSB +: VMID_W];

  // Lookup and fill matching
  logic [NUM_ENT-1:0] lu_match, fill_match;
  logic [IW-1:0]      vic_idx;
  logic               fill_go;

  s2tlb_cam #(.N(NUM_ENT), .TAG_W(TAG_W), .VMID_W(VMID_W)) u_lu_cam (
    .vld(vld_q), .tags(tag_q), .vmids(vmid_q),
    .key_tag(lu_ipa[IPA_W-1:PAGE_W]), .key_vmid(cur_vmid), .hit(lu_match)
  );

  s2tlb_cam #(.N(NUM_ENT), .TAG_W(TAG_W), .VMID_W(VMID_W)) u_fill_cam (
    .vld(vld_q), .tags(tag_q), .vmids(vmid_q),
    .key_tag(fill_ipa[IPA_W-1:PAGE_W]), .key_vmid(fill_vmid), .hit(fill_match)
  );

  assign fill_go = fill_valid && !inv_all && !inv_vmid_valid;

  s2tlb_victim #(.N(NUM_ENT)) u_victim (
    .clk(clk), .rst_n(rst_sync_n), .ent_vld(vld_q), .dup_hit(fill_match),
    .alloc(fill_go), .sel_idx(vic_idx)
  );

  // Entry next state: invalidates take precedence over fills
  always_comb begin
    vld_d = vld_q;
    we    = '0;
    if (inv_all) begin
      vld_d = '0;
    end else if (inv_vmid_valid) begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (vmid_q[i] == inv_vmid) vld_d[i] = 1'b0;
      end
    end else if (fill_valid) begin
      vld_d[vic_idx] = 1'b1;
      we[vic_idx]    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) vld_q <= '0;
    else             vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_ENT; i++) begin
      if (we[i]) begin
        tag_q[i]  <= fill_ipa[IPA_W-1:PAGE_W];
        vmid_q[i] <= fill_vmid;
        ppn_q[i]  <= fill_pa[PA_W-1:PAGE_W];
        rd_q[i]   <= fill_rd;
        wr_q[i]   <= fill_wr;
      end
    end
  end

  // Read-out of the (at most one) matching entry
  logic [PPN_W-1:0] sel_ppn;
  logic             sel_rd, sel_wr, lu_any, perm_ok;
  always_comb begin
    sel_ppn = '0;
    sel_rd  = 1'b0;
    sel_wr  = 1'b0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (lu_match[i]) begin
        sel_ppn = sel_ppn | ppn_q[i];
        sel_rd  = sel_rd | rd_q[i];
        sel_wr  = sel_wr | wr_q[i];
      end
    end
    lu_any  = |lu_match;
    perm_ok = lu_write ? sel_wr : sel_rd;
  end

  // Response next state
  logic              rsp_valid_d, rsp_hit_d, rsp_fault_d, walk_req_d;
  logic [PA_W-1:0]   rsp_pa_d;
  logic [IPA_W-1:0]  walk_ipa_d;
  logic [VMID_W-1:0] walk_vmid_d;
  always_comb begin
    rsp_valid_d = lu_valid;
    rsp_hit_d   = lu_valid && lu_any;
    rsp_fault_d = lu_valid && lu_any && !perm_ok;
    rsp_pa_d    = (lu_valid && lu_any && perm_ok) ? {sel_ppn, lu_ipa[PAGE_W-1:0]} : '0;
    walk_req_d  = lu_valid && !lu_any;
    walk_ipa_d  = walk_req_d ? lu_ipa : '0;
    walk_vmid_d = walk_req_d ? cur_vmid : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pa    <= '0;
      walk_req  <= 1'b0;
      walk_ipa  <= '0;
      walk_vmid <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_hit   <= rsp_hit_d;
      rsp_fault <= rsp_fault_d;
      rsp_pa    <= rsp_pa_d;
      walk_req  <= walk_req_d;
      walk_ipa  <= walk_ipa_d;
      walk_vmid <= walk_vmid_d;
    end
  end
endmodule

// File: rtl/s2tlb_chk.sv
module s2tlb_chk #(
  parameter int N = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] vttb_base,
  input logic        lu_valid,
  input logic [39:0] lu_ipa,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic        rsp_fault,
  input logic [39:0] rsp_pa,
  input logic        walk_req,
  input logic [39:0] walk_ipa,
  input logic [7:0]  walk_vmid,
  input logic        inv_all,
  input logic [N-1:0] ent_vld,
  input logic [N-1:0] lu_match
);
  // R1: response exactly one cycle after a request
  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lu_valid |=> rsp_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !lu_valid |=> !rsp_valid);
  // R2: page offset passes through on a clean hit
  a_r2_offset: assert property (@(posedge clk) disable iff (!rst_n)
    lu_valid |=> ((rsp_hit && !rsp_fault) -> (rsp_pa[11:0] == $past(lu_ipa[11:0]))));
  // R5: walk only on a miss, carrying address and identifier
  a_r5_walk_only_miss: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> (rsp_valid && !rsp_hit && !rsp_fault));
  a_r5_walk_payload: assert property (@(posedge clk) disable iff (!rst_n)
    lu_valid |=> (walk_req -> ((walk_ipa == $past(lu_ipa)) &&
                               (walk_vmid == $past(vttb_base[55:48])))));
  // R6: a fault returns no address
  a_r6_fault_no_pa: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_hit && rsp_pa == 40'd0));
  // R7: never two matching entries
  a_r7_unique: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lu_match));
  // R10: clear-all empties the array
  a_r10_inv_all: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (ent_vld == '0));
endmodule

bind vmid_s2_tlb s2tlb_chk #(.N(NUM_ENT)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .vttb_base(vttb_base), .lu_valid(lu_valid),
  .lu_ipa(lu_ipa), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
  .rsp_pa(rsp_pa), .walk_req(walk_req), .walk_ipa(walk_ipa), .walk_vmid(walk_vmid),
  .inv_all(inv_all), .ent_vld(vld_q), .lu_match(lu_match)
);

// File: tb/vmid_s2_tlb_test.sv
`timescale 1ns/1ps
module vmid_s2_tlb_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] vttb_base;
  logic        lu_valid, lu_write;
  logic [39:0] lu_ipa;
  logic        rsp_valid, rsp_hit, rsp_fault, walk_req;
  logic [39:0] rsp_pa, walk_ipa;
  logic [7:0]  walk_vmid;
  logic        fill_valid, fill_rd, fill_wr;
  logic [39:0] fill_ipa, fill_pa;
  logic [7:0]  fill_vmid;
  logic        inv_all, inv_vmid_valid;
  logic [7:0]  inv_vmid;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  vmid_s2_tlb uut (
    .clk(clk), .rst_n(rst_n), .vttb_base(vttb_base), .lu_valid(lu_valid),
    .lu_ipa(lu_ipa), .lu_write(lu_write), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_fault(rsp_fault), .rsp_pa(rsp_pa), .walk_req(walk_req), .walk_ipa(walk_ipa),
    .walk_vmid(walk_vmid), .fill_valid(fill_valid), .fill_ipa(fill_ipa),
    .fill_vmid(fill_vmid), .fill_pa(fill_pa), .fill_rd(fill_rd), .fill_wr(fill_wr),
    .inv_all(inv_all), .inv_vmid_valid(inv_vmid_valid), .inv_vmid(inv_vmid)
  );

  // Vector: {vmid 8, ipa 40, write 1, hit 1, fault 1, pa 40}
  localparam int VW = 91;
  localparam int NV = 7;
  localparam logic [VW-1:0] VEC [NV] = '{
    {8'h05, 40'h00_0000_1ABC, 1'b0, 1'b1, 1'b0, 40'h00_ABCD_EABC},
    {8'h05, 40'h00_0000_2123, 1'b1, 1'b1, 1'b1, 40'h0},
    {8'h05, 40'h00_0000_2123, 1'b0, 1'b1, 1'b0, 40'h00_1234_5123},
    {8'h07, 40'h00_0000_1FFF, 1'b0, 1'b1, 1'b0, 40'h00_5555_5FFF},
    {8'h09, 40'h00_0000_1000, 1'b0, 1'b0, 1'b0, 40'h0},
    {8'h05, 40'h00_0000_1000, 1'b1, 1'b1, 1'b0, 40'h00_ABCD_E000},
    {8'h05, 40'hFF_FFFF_F001, 1'b0, 1'b0, 1'b0, 40'h0}
  };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_vmid(input logic [7:0] v, input logic [7:0] junk);
    vttb_base = {junk, v, 48'h9ABC_1234_5678 ^ {6{junk}}};
  endtask

  // Lookup then compare {valid,hit,fault,pa} and the walk outputs
  task automatic look(input string req, input logic [7:0] v, input logic [39:0] ipa,
                      input logic wr, input logic eh, input logic ef, input logic [39:0] epa);
    @(negedge clk);
    set_vmid(v, 8'h3C);
    lu_valid = 1'b1; lu_ipa = ipa; lu_write = wr;
    @(posedge clk);
    @(negedge clk);
    lu_valid = 1'b0;
    check(req, {rsp_valid, rsp_hit, rsp_fault, rsp_pa}, {1'b1, eh, ef, epa});
    check(req, {walk_req, walk_ipa, walk_vmid},
          eh ? {1'b0, 40'h0, 8'h0} : {1'b1, ipa, v});
  endtask

  task automatic fill(input logic [7:0] v, input logic [27:0] pg, input logic [27:0] fr,
                      input logic r, input logic w);
    @(negedge clk);
    fill_valid = 1'b1; fill_vmid = v; fill_ipa = {pg, 12'h5A5};
    fill_pa = {fr, 12'hFFF}; fill_rd = r; fill_wr = w;
    @(posedge clk);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; vttb_base = '0; lu_valid = 1'b0; lu_ipa = '0; lu_write = 1'b0;
    fill_valid = 1'b0; fill_ipa = '0; fill_vmid = '0; fill_pa = '0; fill_rd = 1'b0;
    fill_wr = 1'b0; inv_all = 1'b0; inv_vmid_valid = 1'b0; inv_vmid = '0;
    repeat (3) @(negedge clk);
    check("R12 reset outputs", {rsp_valid, walk_req}, 2'b00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R12 idle after reset", {rsp_valid, walk_req}, 2'b00);
    look("R12 R5 empty miss", 8'h05, 40'h00_0000_1ABC, 1'b0, 1'b0, 1'b0, 40'h0);

    fill(8'h05, 28'h1, 28'h00ABCDE, 1'b1, 1'b1);
    fill(8'h05, 28'h2, 28'h0012345, 1'b1, 1'b0);
    fill(8'h07, 28'h1, 28'h0055555, 1'b1, 1'b1);

    // Vector walk; the junk bits around the identifier vary (R3)
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] e;
      e = VEC[i];
      @(negedge clk);
      set_vmid(e[90:83], 8'(i * 37 + 1));
      lu_valid = 1'b1; lu_ipa = e[82:43]; lu_write = e[42];
      @(posedge clk);
      @(negedge clk);
      lu_valid = 1'b0;
      check($sformatf("R2 R3 R4 R6 vector %0d", i),
            {rsp_valid, rsp_hit, rsp_fault, rsp_pa}, {1'b1, e[41], e[40], e[39:0]});
      check($sformatf("R5 vector %0d walk", i), walk_req, !e[41]);
    end
    @(negedge clk);
    check("R1 no response without request", rsp_valid, 1'b0);

    // R7: overwrite, then fill exactly to capacity
    fill(8'h05, 28'h1, 28'h000FFFF, 1'b1, 1'b1);
    look("R7 overwritten frame", 8'h05, 40'h00_0000_1ABC, 1'b0, 1'b1, 1'b0, 40'h00_0FFF_FABC);
    for (int k = 0; k < 13; k++) fill(8'h03, 28'h100 + 28'(k), 28'h200 + 28'(k), 1'b1, 1'b1);
    look("R7 no duplicate evicts p2", 8'h05, 40'h00_0000_2010, 1'b0, 1'b1, 1'b0, 40'h00_1234_5010);
    look("R7 no duplicate evicts v7", 8'h07, 40'h00_0000_1010, 1'b0, 1'b1, 1'b0, 40'h00_5555_5010);
    look("R7 newest resident", 8'h03, 40'h00_0010_C777, 1'b0, 1'b1, 1'b0, 40'h00_0020_C777);

    // R9: clear identifier 5 only
    @(negedge clk);
    inv_vmid_valid = 1'b1; inv_vmid = 8'h05;
    @(negedge clk);
    inv_vmid_valid = 1'b0;
    look("R9 cleared p1", 8'h05, 40'h00_0000_1000, 1'b0, 1'b0, 1'b0, 40'h0);
    look("R9 cleared p2", 8'h05, 40'h00_0000_2000, 1'b0, 1'b0, 1'b0, 40'h0);
    look("R9 other id kept", 8'h07, 40'h00_0000_1000, 1'b0, 1'b1, 1'b0, 40'h00_5555_5000);
    look("R9 id 3 kept", 8'h03, 40'h00_0010_5000, 1'b0, 1'b1, 1'b0, 40'h00_0020_5000);

    // R8: holes 0 and 1 refilled, then round-robin from entry 0
    fill(8'h09, 28'h300, 28'h400, 1'b1, 1'b1);
    fill(8'h09, 28'h301, 28'h401, 1'b1, 1'b1);
    fill(8'h09, 28'h302, 28'h402, 1'b1, 1'b1);
    fill(8'h09, 28'h303, 28'h403, 1'b1, 1'b1);
    look("R8 first victim", 8'h09, 40'h00_0030_0000, 1'b0, 1'b0, 1'b0, 40'h0);
    look("R8 second victim", 8'h09, 40'h00_0030_1000, 1'b0, 1'b0, 1'b0, 40'h0);
    look("R8 new fill", 8'h09, 40'h00_0030_3000, 1'b0, 1'b1, 1'b0, 40'h00_0040_3000);
    look("R8 entry 2 kept", 8'h07, 40'h00_0000_1000, 1'b0, 1'b1, 1'b0, 40'h00_5555_5000);
    look("R4 no global match", 8'h00, 40'h00_0010_0000, 1'b0, 1'b0, 1'b0, 40'h0);

    // R11: lookup during a fill sees old contents; pointer now at entry 2
    @(negedge clk);
    set_vmid(8'h09, 8'h11);
    lu_valid = 1'b1; lu_ipa = 40'h00_0030_4000; lu_write = 1'b0;
    fill_valid = 1'b1; fill_vmid = 8'h09; fill_ipa = 40'h00_0030_4000;
    fill_pa = 40'h00_0040_4000; fill_rd = 1'b1; fill_wr = 1'b0;
    @(posedge clk);
    @(negedge clk);
    lu_valid = 1'b0; fill_valid = 1'b0;
    check("R11 lookup with fill sees old", {rsp_hit, walk_req}, 2'b01);
    look("R11 fill visible next", 8'h09, 40'h00_0030_4ABC, 1'b0, 1'b1, 1'b0, 40'h00_0040_4ABC);
    look("R6 write to read-only", 8'h09, 40'h00_0030_4ABC, 1'b1, 1'b1, 1'b1, 40'h0);
    look("R8 pointer advanced to 2", 8'h07, 40'h00_0000_1000, 1'b0, 1'b0, 1'b0, 40'h0);

    // R11: fill with an invalidate is dropped
    @(negedge clk);
    fill_valid = 1'b1; fill_vmid = 8'h04; fill_ipa = 40'h00_0040_0000;
    fill_pa = 40'h00_0050_0000; fill_rd = 1'b1; fill_wr = 1'b1;
    inv_vmid_valid = 1'b1; inv_vmid = 8'hEE;
    @(negedge clk);
    fill_valid = 1'b0; inv_vmid_valid = 1'b0;
    look("R11 fill dropped", 8'h04, 40'h00_0040_0000, 1'b0, 1'b0, 1'b0, 40'h0);

    // R10: clear all
    @(negedge clk);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    look("R10 id 3 gone", 8'h03, 40'h00_0010_5000, 1'b0, 1'b0, 1'b0, 40'h0);
    look("R10 id 9 gone", 8'h09, 40'h00_0030_3000, 1'b0, 1'b0, 1'b0, 40'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule